// File: doc/BRIEF.md
# Offset-Binary Signed Multiplier

This block multiplies two N-bit two's-complement operands and returns their full 2N-bit two's-complement product. The multiplier array inside is purely unsigned. Each operand is first moved into offset-binary form by inverting its most significant bit, which adds 2^(N-1). Both values are then non-negative and go into a plain N-by-N unsigned multiply.

The raw product carries two extra terms, and a fixed correction removes them. The operand sum, sign-extended to N+1 bits and shifted left by N-1, is subtracted. The single bit just below the product's MSB, 2^(2N-2), is also subtracted with ordinary borrow.

The work is split over two registered stages. The first stage holds the unsigned product and the operand sum. The second stage holds the corrected result. A valid strobe travels alongside the data, so a new operand pair can enter on every cycle.

Top module: `offsetSignedMul`

## Requirements
- R1: For every pair of operands in the range -2^(N-1) to 2^(N-1)-1, `product` interpreted as a 2N-bit two's-complement number equals the signed product of `xIn` and `yIn`.
- R2: With N=8, operands -60 and +50 give -3000 (16'hF448), not the unsigned pattern for 196 times 50.
- R3: When both operands equal -2^(N-1), the result is +2^(2N-2), with bit 2N-1 clear and bit 2N-2 set.
- R4: When either operand is zero, the result is zero.
- R5: `validOut` rises exactly two clock cycles after each cycle in which `validIn` is sampled high. Back-to-back inputs give back-to-back results in the same order.
- R6: While `rst` is sampled high, both pipeline stages clear. On the following cycle `validOut` is 0 and `product` is 0, and any operand pair already in flight produces no result.
- R7: In a cycle where `validIn` is sampled low, operand values have no effect: `product` keeps the last result until a new valid pair reaches the output.
- R8: With N=3, operands 3 and -3 give -9, which is 6'b110111.
- R9: A positive operand times a negative operand, neither zero, gives a result with bit 2N-1 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| validIn | input | 1 | Marks `xIn` and `yIn` as a pair to multiply |
| xIn | input | N | First operand, two's complement |
| yIn | input | N | Second operand, two's complement |
| validOut | output | 1 | Marks `product` as a new result |
| product | output | 2N | Signed product, two's complement |

## Verification
The hardest situation to reach is the operand sum at its extremes. When both inputs sit at the most negative value, the sign-extended sum and the constant term are the only things that keep the correction from wrapping. The stimulus reaches this point by streaming every operand pair of an 8-bit and a 3-bit instance back to back. A 32-bit instance gets random pairs plus the explicit extremes. A reset asserted while a pair is in flight checks that no stale result escapes, and an idle window with changing operands checks that the output holds.

// File: rtl/offsetMulPkg.sv
package offsetMulPkg;
  typedef struct packed {
    logic loadMul;
    logic loadFix;
  } pipeStrobes_t;
endpackage

// File: rtl/offsetMulCtrl.sv
module offsetMulCtrl
  import offsetMulPkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         validIn,
  output pipeStrobes_t strobes,
  output logic         validOut
);
  logic stageOneValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      stageOneValid <= 1'b0;
      validOut      <= 1'b0;
    end else begin
      stageOneValid <= validIn;
      validOut      <= stageOneValid;
    end
  end

  always_comb begin
    strobes.loadMul = validIn;
    strobes.loadFix = stageOneValid;
  end

  // R5: a valid pair reaches the output after exactly two cycles
  assert_valid_latency_R5: assert property (@(posedge clk) disable iff (rst)
    validIn |-> ##2 validOut);
  assert_no_spurious_valid_R5: assert property (@(posedge clk) disable iff (rst)
    !validIn |-> ##2 !validOut);
  // R6: reset leaves the output strobe low
  assert_reset_clears_R6: assert property (@(posedge clk)
    rst |=> !validOut && !stageOneValid);
endmodule

// File: rtl/offsetMulDatapath.sv
module offsetMulDatapath
  import offsetMulPkg::*;
#(
  parameter int N = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  pipeStrobes_t     strobes,
  input  logic [N-1:0]     xIn,
  input  logic [N-1:0]     yIn,
  output logic [2*N-1:0]   product
);
  localparam int PW = 2 * N;
  localparam int SW = N + 1;
  localparam logic [N-1:0]  MOST_NEG = {1'b1, {(N-1){1'b0}}};
  localparam logic [PW-1:0] BIAS_SQ  = {2'b01, {(PW-2){1'b0}}};

  logic [N-1:0]  xOff, yOff;
  logic [PW-1:0] rawProd, rawProdReg;
  logic [SW-1:0] opSum, opSumReg;
  logic [PW-1:0] crossTerm, fixedProd;

  // offset-binary conversion: flip only the sign bit
  always_comb begin
    xOff    = {~xIn[N-1], xIn[N-2:0]};
    yOff    = {~yIn[N-1], yIn[N-2:0]};
    rawProd = PW'(xOff) * PW'(yOff);
    opSum   = {xIn[N-1], xIn} + {yIn[N-1], yIn};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rawProdReg <= '0;
      opSumReg   <= '0;
    end else if (strobes.loadMul) begin
      rawProdReg <= rawProd;
      opSumReg   <= opSum;
    end
  end

  always_comb begin
    crossTerm = {opSumReg, {(N-1){1'b0}}};
    fixedProd = rawProdReg - crossTerm - BIAS_SQ;
  end

  always_ff @(posedge clk) begin
    if (rst) product <= '0;
    else if (strobes.loadFix) product <= fixedProd;
  end

  // R3: most negative squared lands on the bit below the MSB
  assert_min_square_R3: assert property (@(posedge clk) disable iff (rst)
    strobes.loadMul && xIn == MOST_NEG && yIn == MOST_NEG |-> ##2 product == BIAS_SQ);
  // R4: a zero operand gives zero
  assert_zero_operand_R4: assert property (@(posedge clk) disable iff (rst)
    strobes.loadMul && (xIn == '0 || yIn == '0) |-> ##2 product == '0);
  // R9: mixed signs give a negative result
  assert_mixed_sign_R9: assert property (@(posedge clk) disable iff (rst)
    strobes.loadMul && !xIn[N-1] && xIn != '0 && yIn[N-1] |-> ##2 product[PW-1]);
  // R7: no stage-two strobe, no change
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadFix |=> $stable(product));
  // R6: reset clears the result
  assert_reset_product_R6: assert property (@(posedge clk)
    rst |=> product == '0);
endmodule

// File: rtl/offsetSignedMul.sv
module offsetSignedMul
  import offsetMulPkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           validIn,
  input  logic [N-1:0]   xIn,
  input  logic [N-1:0]   yIn,
  output logic           validOut,
  output logic [2*N-1:0] product
);
  pipeStrobes_t strobes;

  initial begin
    assert (N >= 2 && N <= 32) else $error("N out of range");
  end

  offsetMulCtrl u_ctrl (
    .clk(clk), .rst(rst), .validIn(validIn),
    .strobes(strobes), .validOut(validOut)
  );

  offsetMulDatapath #(.N(N)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .xIn(xIn), .yIn(yIn), .product(product)
  );
endmodule

// File: tb/offsetSignedMul_bench.sv
module offsetSignedMul_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic validIn = 1'b0;
  logic [7:0]  x8 = '0, y8 = '0;
  logic [2:0]  x3 = '0, y3 = '0;
  logic [31:0] x32 = '0, y32 = '0;
  logic vo8, vo3, vo32;
  logic [15:0] p8;
  logic [5:0]  p3;
  logic [63:0] p32;

  int checks = 0;
  int errors = 0;
  int cycle  = 0;
  longint exp8[$], exp3[$], exp32[$];
  int     sent[$];
  string  tag8[$];

  always #4 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  offsetSignedMul #(.N(8)) u_offsetSignedMul (
    .clk(clk), .rst(rst), .validIn(validIn), .xIn(x8), .yIn(y8),
    .validOut(vo8), .product(p8));
  offsetSignedMul #(.N(3)) u_offsetSignedMul_n3 (
    .clk(clk), .rst(rst), .validIn(validIn), .xIn(x3), .yIn(y3),
    .validOut(vo3), .product(p3));
  offsetSignedMul #(.N(32)) u_offsetSignedMul_n32 (
    .clk(clk), .rst(rst), .validIn(validIn), .xIn(x32), .yIn(y32),
    .validOut(vo32), .product(p32));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] a8, input logic [7:0] b8, input logic [2:0] a3,
                      input logic [2:0] b3, input logic [31:0] a32, input logic [31:0] b32,
                      input string tag);
    x8 = a8; y8 = b8; x3 = a3; y3 = b3; x32 = a32; y32 = b32;
    validIn = 1'b1;
    exp8.push_back(longint'($signed(a8)) * longint'($signed(b8)));
    exp3.push_back(longint'($signed(a3)) * longint'($signed(b3)));
    exp32.push_back(longint'($signed(a32)) * longint'($signed(b32)));
    tag8.push_back(tag);
    sent.push_back(cycle);
    @(negedge clk);
    validIn = 1'b0;
  endtask

  // monitor: compare results as they emerge
  always @(negedge clk) begin
    if (!rst && vo8) begin
      if (exp8.size() == 0) check(1'b0, "R5 unexpected valid", 1, 0);
      else begin
        longint e8, e3, e32;
        int s;
        string t;
        e8 = exp8.pop_front(); e3 = exp3.pop_front(); e32 = exp32.pop_front();
        s = sent.pop_front(); t = tag8.pop_front();
        check(longint'($signed(p8)) == e8, t, longint'($signed(p8)), e8);
        check(longint'($signed(p3)) == e3, "R1 n3", longint'($signed(p3)), e3);
        check(longint'($signed(p32)) == e32, "R1 n32", longint'($signed(p32)), e32);
        check(cycle - s == 2, "R5 latency", longint'(cycle - s), 2);
        check(vo3 && vo32, "R5 valid alignment", longint'(vo3 & vo32), 1);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R6: reset state
    check(vo8 == 1'b0, "R6 reset validOut", longint'(vo8), 0);
    check(p8 == '0, "R6 reset product", longint'(p8), 0);
    rst = 1'b0;
    @(negedge clk);

    // R6: reset while a pair is in flight
    x8 = 8'd7; y8 = 8'd9; validIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0; rst = 1'b1;
    @(negedge clk);
    check(vo8 == 1'b0, "R6 in-flight dropped", longint'(vo8), 0);
    check(p8 == '0, "R6 product cleared", longint'(p8), 0);
    rst = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(vo8 == 1'b0, "R6 no stale result", longint'(vo8), 0);
    end

    // directed cases
    send(8'sd196 - 8'sd0, 8'd50, 3'd3, 3'b101, 32'd3, -32'sd3, "R2 -60*50");
    send(8'h80, 8'h80, 3'b100, 3'b100, 32'h8000_0000, 32'h8000_0000, "R3 min*min");
    send(8'd0, 8'h80, 3'd0, 3'b100, 32'd0, 32'h8000_0000, "R4 zero");
    send(8'd127, 8'h81, 3'd3, 3'b111, 32'h7fff_ffff, 32'h8000_0001, "R9 mixed sign");
    send(8'h7f, 8'h7f, 3'd3, 3'd3, 32'h7fff_ffff, 32'h7fff_ffff, "R1 max*max");
    repeat (3) @(negedge clk);

    // R8: explicit 3-bit case -9 = 6'b110111
    x3 = 3'd3; y3 = 3'b101; validIn = 1'b1;
    exp8.push_back(0); exp3.push_back(-9); exp32.push_back(0);
    tag8.push_back("R8 filler"); sent.push_back(cycle);
    x8 = 8'd0; y8 = 8'd0; x32 = '0; y32 = '0;
    @(negedge clk); validIn = 1'b0;
    @(negedge clk);
    check(p3 == 6'b110111, "R8 3*-3", longint'(p3), 6'b110111);
    @(negedge clk);

    // R1: exhaustive 8-bit and 3-bit, random 32-bit, back to back
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        send(8'(i), 8'(j), 3'(i), 3'(j), $urandom, $urandom, "R1 exhaustive");
        validIn = 1'b0;
        x8 = 8'(i); y8 = 8'(j + 1);
        if (j != 255) begin
          validIn = 1'b1;
          exp8.push_back(longint'($signed(8'(i))) * longint'($signed(8'(j + 1))));
          x3 = 3'(i); y3 = 3'(j + 1);
          exp3.push_back(longint'($signed(x3)) * longint'($signed(y3)));
          x32 = $urandom; y32 = $urandom;
          exp32.push_back(longint'($signed(x32)) * longint'($signed(y32)));
          tag8.push_back("R5 back-to-back"); sent.push_back(cycle);
          @(negedge clk);
          validIn = 1'b0;
          j++;
        end
      end
    end
    repeat (3) @(negedge clk);

    // R7: idle operands have no effect
    held = p8;
    for (int k = 0; k < 6; k++) begin
      x8 = 8'($urandom); y8 = 8'($urandom);
      @(negedge clk);
      check(p8 == held && !vo8, "R7 hold", longint'(p8), longint'(held));
    end
    check(exp8.size() == 0, "R5 all results seen", longint'(exp8.size()), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule